// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

At every instruction boundary a processor core has to decide whether to keep executing or to divert into a handler. This block makes that decision. It holds the pending state for asynchronous and trap events: a system-management request, a non-maskable interrupt, accumulated debug trap bits, a resume flag, a one-boundary inhibit mask and a halt indication. When the core offers a boundary, the block applies a fixed priority ladder and emits at most one service command. That command carries a kind, a vector and an external-event marker.

The core offers a boundary on a valid/ready pair. `bnd_ready` is high only while the arbiter is idle. An offer is accepted on a clock edge where `bnd_valid` and `bnd_ready` are both high. A boundary that selects nothing completes on that same edge. A boundary that selects a maskable interrupt first raises `iack_req` and waits for `iack_valid`, which carries the vector. The service command is presented with `cmd_valid` and holds its contents until the edge where `cmd_ready` is sampled high. No new boundary is accepted before that edge. The event inputs (`smi_evt`, `nmi_evt`, `trap_evt`, `inhibit_evt`, `rf_evt`, `halt_evt`, `nmi_unmask`) are single-cycle pulses and may arrive on any cycle. The pending state they set becomes visible on the status outputs after the next edge.

Top module: `evt_arb`

## Requirements
- R1: At most one command is issued per accepted boundary. `cmd_kind` is one-hot: bit 0 debug exception, bit 1 system-management entry, bit 2 NMI, bit 3 maskable interrupt, bit 4 bus-hold grant. `cmd_valid` and the command contents stay stable until `cmd_ready`. `bnd_ready` stays low while a command or an acknowledge is outstanding.
- R2: If trap bit 15 (task-switch trap) is pending, it wins over every other event. The block ORs the pending trap bits into `dbg_status`, issues a debug command with vector 1 and no external mark, and clears the pending trap bits.
- R3: A pending SMI is the next-highest event and is taken only when `in_smm` is low. Taking it clears the SMI pending flag and sets `nmi_disable`. While `in_smm` is high, the SMI stays pending and lower-priority events are arbitrated.
- R4: Any other nonzero pending trap bits raise a debug command, vector 1, only when inhibit bit 0 (debug inhibit) is clear. The bits are ORed into `dbg_status` and then cleared. When debug inhibit is set, the bits stay pending.
- R5: Inhibit bit 1 (interrupt inhibit) blocks NMI, maskable interrupt and bus-hold service for the boundary on which it is set.
- R6: An NMI is taken when it is pending and `nmi_disable` is low. The command has vector 2 and the external mark. Taking it clears NMI pending and sets `nmi_disable`. A `nmi_unmask` pulse clears `nmi_disable`, except when an NMI or SMI is taken on the same edge.
- R7: A maskable interrupt is served when `intr_req` and `if_flag` are both high. The block raises `iack_req` until `iack_valid`, then issues the command with `iack_vector` and the external mark.
- R8: Bus hold has the lowest priority among the external events. It is granted when `hold_req` is high and nothing above it was chosen. The command has vector 0.
- R9: When `tf_flag` is high and the boundary issues no command, or only a bus-hold grant, trap bit 14 (single-step) becomes pending.
- R10: If `resume` is set, an evaluated boundary clears it and skips the breakpoint compare. Otherwise, when `bp_enable` is high and `bp_match` is nonzero, one of two things happens. If no command was chosen and debug inhibit is clear, a debug command is issued and the `bp_match` bits are ORed into the low bits of `dbg_status`. If not, the `bp_match` bits are added to the pending trap bits.
- R11: While `halted` is high, a boundary issues nothing and changes no state unless a wake condition holds. The wake conditions are: `intr_req` together with `if_flag` or `mwait_ovr`, a pending NMI, or a pending SMI. A wake clears `halted`, the pending trap bits and the inhibit mask, and the boundary is then arbitrated normally.
- R12: Every evaluated boundary clears the inhibit mask. After the boundary, `event_pending` equals the OR of: SMI pending, NMI pending, `intr_req` with `if_flag`, any pending trap bit, `hold_req`, `tf_flag` and `bp_enable`. SMI, NMI and nonzero trap event pulses set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid | input | 1 | Core offers an instruction boundary |
| bnd_ready | output | 1 | Arbiter idle and able to accept a boundary |
| if_flag | input | 1 | Interrupt enable flag, sampled with the boundary |
| tf_flag | input | 1 | Single-step flag, sampled with the boundary |
| in_smm | input | 1 | Core is already in system-management mode |
| mwait_ovr | input | 1 | Monitor-wait override: lets interrupts wake the core from halt when the interrupt flag is clear |
| intr_req | input | 1 | Maskable interrupt request level |
| hold_req | input | 1 | Bus hold request level |
| bp_enable | input | 1 | Any instruction breakpoint enabled |
| bp_match | input | BP_N | Instruction breakpoint compare hits |
| smi_evt | input | 1 | Pulse: SMI delivered |
| nmi_evt | input | 1 | Pulse: NMI delivered |
| nmi_unmask | input | 1 | Pulse: clear NMI disable |
| halt_evt | input | 1 | Pulse: core enters halt |
| rf_evt | input | 1 | Pulse: set resume flag |
| trap_evt | input | TRAP_W | Pulse: trap bits to add to pending |
| inhibit_evt | input | 2 | Pulse: inhibit bits to set (bit 0 debug, bit 1 interrupt) |
| iack_req | output | 1 | Interrupt acknowledge request |
| iack_valid | input | 1 | Acknowledge returned with a vector |
| iack_vector | input | VEC_W | Vector of the acknowledged interrupt |
| cmd_valid | output | 1 | Service command valid |
| cmd_ready | input | 1 | Core accepts the service command |
| cmd_kind | output | 5 | One-hot command kind |
| cmd_vector | output | VEC_W | Command vector |
| cmd_external | output | 1 | Command originates from an external event |
| dbg_status | output | TRAP_W | Accumulated debug status bits |
| trap_pending | output | TRAP_W | Pending debug trap bits |
| inhibit | output | 2 | Current inhibit mask |
| resume | output | 1 | Resume flag |
| smi_pending | output | 1 | SMI pending |
| nmi_pending | output | 1 | NMI pending |
| nmi_disable | output | 1 | NMI lockout |
| halted | output | 1 | Core halted |
| event_pending | output | 1 | Summary: something may need service at the next boundary |

## Verification
All pending-state outputs are registered from the edge that accepts the boundary. The bench therefore samples them on the following falling edge and compares them with its own model. A command without an acknowledge appears on that same falling edge. An interrupt command appears one cycle after the edge that samples `iack_valid`. The bench checks `iack_req` first, then drives the acknowledge, then looks for the command. Before raising `cmd_ready`, the bench holds it low for a random 0 to 2 cycles and re-checks that the command stays stable during those cycles. Event pulses are given in idle cycles, away from boundary offers, so the expected state after each step is unambiguous.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  localparam int unsigned KIND_W = 5;
  localparam int unsigned K_DBG  = 0;
  localparam int unsigned K_SMI  = 1;
  localparam int unsigned K_NMI  = 2;
  localparam int unsigned K_INT  = 3;
  localparam int unsigned K_HOLD = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TSW, SEL_SMI, SEL_DBG, SEL_NMI, SEL_INTR, SEL_HOLD, SEL_BP
  } sel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_CMD} fsm_e;
endpackage

// File: rtl/evt_arb_pick.sv
module evt_arb_pick
  import evt_arb_pkg::*;
#(
  parameter int unsigned TRAP_W  = 16,
  parameter int unsigned BP_N    = 4,
  parameter int unsigned TSW_BIT = 15
) (
  input  logic              halted_q,
  input  logic              smi_q,
  input  logic              nmi_q,
  input  logic              dis_q,
  input  logic              rf_q,
  input  logic [TRAP_W-1:0] trap_q,
  input  logic [1:0]        inh_q,
  input  logic              in_smm,
  input  logic              if_flag,
  input  logic              mwait_ovr,
  input  logic              intr_req,
  input  logic              hold_req,
  input  logic              bp_enable,
  input  logic [BP_N-1:0]   bp_match,
  output sel_e              sel,
  output logic              frozen,
  output logic              bp_hit,
  output logic [TRAP_W-1:0] trap_eff,
  output logic [1:0]        inh_eff
);
  logic wake;
  logic ext_ok;

  always_comb begin
    wake     = (intr_req && (if_flag || mwait_ovr)) || nmi_q || smi_q;
    frozen   = halted_q && !wake;
    trap_eff = halted_q ? '0 : trap_q;
    inh_eff  = halted_q ? 2'b00 : inh_q;
    bp_hit   = !rf_q && bp_enable && (|bp_match);
    ext_ok   = !inh_eff[1];

    if (frozen)                                 sel = SEL_NONE;
    else if (trap_eff[TSW_BIT])                 sel = SEL_TSW;
    else if (smi_q && !in_smm)                  sel = SEL_SMI;
    else if ((|trap_eff) && !inh_eff[0])        sel = SEL_DBG;
    else if (ext_ok && nmi_q && !dis_q)         sel = SEL_NMI;
    else if (ext_ok && intr_req && if_flag)     sel = SEL_INTR;
    else if (ext_ok && hold_req)                sel = SEL_HOLD;
    else if (bp_hit && !inh_eff[0])             sel = SEL_BP;
    else                                        sel = SEL_NONE;
  end
endmodule

// File: rtl/evt_arb_flags.sv
module evt_arb_flags
  import evt_arb_pkg::*;
#(
  parameter int unsigned TRAP_W    = 16,
  parameter int unsigned BP_N      = 4,
  parameter int unsigned SSTEP_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  sel_e              sel,
  input  logic              frozen,
  input  logic              bp_hit,
  input  logic [TRAP_W-1:0] trap_eff,
  input  logic [BP_N-1:0]   bp_match,
  input  logic              tf_flag,
  input  logic              if_flag,
  input  logic              intr_req,
  input  logic              hold_req,
  input  logic              bp_enable,
  input  logic              smi_evt,
  input  logic              nmi_evt,
  input  logic              nmi_unmask,
  input  logic              halt_evt,
  input  logic              rf_evt,
  input  logic [TRAP_W-1:0] trap_evt,
  input  logic [1:0]        inhibit_evt,
  output logic              smi_q,
  output logic              nmi_q,
  output logic              dis_q,
  output logic              halted_q,
  output logic              rf_q,
  output logic              evp_q,
  output logic [TRAP_W-1:0] trap_q,
  output logic [TRAP_W-1:0] stat_q,
  output logic [1:0]        inh_q
);
  logic              evaluating, is_dbg, step_set;
  logic [TRAP_W-1:0] bp_bits, step_bits;
  logic              smi_n, nmi_n, dis_n, halted_n, rf_n, evp_n;
  logic [TRAP_W-1:0] trap_n, stat_n;
  logic [1:0]        inh_n;

  for (genvar b = 0; b < TRAP_W; b++) begin : g_bp_map
    if (b < BP_N) begin : g_hit
      assign bp_bits[b] = bp_hit && bp_match[b];
    end else begin : g_zero
      assign bp_bits[b] = 1'b0;
    end
  end

  always_comb begin
    evaluating = accept && !frozen;
    is_dbg     = (sel == SEL_TSW) || (sel == SEL_DBG) || (sel == SEL_BP);
    step_set   = tf_flag && ((sel == SEL_NONE) || (sel == SEL_HOLD));
    step_bits  = '0;
    step_bits[SSTEP_BIT] = step_set;

    smi_n    = smi_q;
    nmi_n    = nmi_q;
    dis_n    = dis_q;
    halted_n = halted_q;
    rf_n     = rf_q;
    evp_n    = evp_q;
    trap_n   = trap_q;
    stat_n   = stat_q;
    inh_n    = inh_q;

    if (nmi_unmask) dis_n = 1'b0;

    if (evaluating) begin
      halted_n = 1'b0;
      rf_n     = 1'b0;
      inh_n    = 2'b00;
      if (sel == SEL_SMI) begin
        smi_n = 1'b0;
        dis_n = 1'b1;
      end
      if (sel == SEL_NMI) begin
        nmi_n = 1'b0;
        dis_n = 1'b1;
      end
      if ((sel == SEL_TSW) || (sel == SEL_DBG)) stat_n = stat_q | trap_eff;
      if (sel == SEL_BP)                        stat_n = stat_q | bp_bits;
      trap_n = is_dbg ? '0 : (trap_eff | bp_bits | step_bits);
      evp_n  = smi_n || nmi_n || (intr_req && if_flag) || (|trap_n) ||
               hold_req || tf_flag || bp_enable;
    end

    smi_n  = smi_n | smi_evt;
    nmi_n  = nmi_n | nmi_evt;
    trap_n = trap_n | trap_evt;
    inh_n  = inh_n | inhibit_evt;
    if (rf_evt)   rf_n     = 1'b1;
    if (halt_evt) halted_n = 1'b1;
    evp_n = evp_n | smi_evt | nmi_evt | (|trap_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_q    <= 1'b0;
      nmi_q    <= 1'b0;
      dis_q    <= 1'b0;
      halted_q <= 1'b0;
      rf_q     <= 1'b0;
      evp_q    <= 1'b0;
      trap_q   <= '0;
      stat_q   <= '0;
      inh_q    <= 2'b00;
    end else begin
      smi_q    <= smi_n;
      nmi_q    <= nmi_n;
      dis_q    <= dis_n;
      halted_q <= halted_n;
      rf_q     <= rf_n;
      evp_q    <= evp_n;
      trap_q   <= trap_n;
      stat_q   <= stat_n;
      inh_q    <= inh_n;
    end
  end
endmodule

// File: rtl/evt_arb.sv
module evt_arb
  import evt_arb_pkg::*;
#(
  parameter int unsigned TRAP_W    = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned BP_N      = 4,
  parameter int unsigned TSW_BIT   = 15,
  parameter int unsigned SSTEP_BIT = 14,
  parameter int unsigned NMI_VEC   = 2,
  parameter int unsigned DBG_VEC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_valid,
  output logic              bnd_ready,
  input  logic              if_flag,
  input  logic              tf_flag,
  input  logic              in_smm,
  input  logic              mwait_ovr,
  input  logic              intr_req,
  input  logic              hold_req,
  input  logic              bp_enable,
  input  logic [BP_N-1:0]   bp_match,
  input  logic              smi_evt,
  input  logic              nmi_evt,
  input  logic              nmi_unmask,
  input  logic              halt_evt,
  input  logic              rf_evt,
  input  logic [TRAP_W-1:0] trap_evt,
  input  logic [1:0]        inhibit_evt,
  output logic              iack_req,
  input  logic              iack_valid,
  input  logic [VEC_W-1:0]  iack_vector,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [4:0]        cmd_kind,
  output logic [VEC_W-1:0]  cmd_vector,
  output logic              cmd_external,
  output logic [TRAP_W-1:0] dbg_status,
  output logic [TRAP_W-1:0] trap_pending,
  output logic [1:0]        inhibit,
  output logic              resume,
  output logic              smi_pending,
  output logic              nmi_pending,
  output logic              nmi_disable,
  output logic              halted,
  output logic              event_pending
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] DBG_V = VEC_W'(DBG_VEC);

  fsm_e              st_q;
  sel_e              sel;
  logic              accept, frozen, bp_hit;
  logic [TRAP_W-1:0] trap_eff;
  logic [1:0]        inh_eff;
  logic [KIND_W-1:0] kind_q;
  logic [VEC_W-1:0]  vec_q;
  logic              ext_q;

  assign bnd_ready = (st_q == ST_IDLE);
  assign accept    = bnd_valid && bnd_ready;

  evt_arb_pick #(.TRAP_W(TRAP_W), .BP_N(BP_N), .TSW_BIT(TSW_BIT)) u_pick (
    .halted_q(halted), .smi_q(smi_pending), .nmi_q(nmi_pending),
    .dis_q(nmi_disable), .rf_q(resume), .trap_q(trap_pending), .inh_q(inhibit),
    .in_smm(in_smm), .if_flag(if_flag), .mwait_ovr(mwait_ovr),
    .intr_req(intr_req), .hold_req(hold_req), .bp_enable(bp_enable),
    .bp_match(bp_match), .sel(sel), .frozen(frozen), .bp_hit(bp_hit),
    .trap_eff(trap_eff), .inh_eff(inh_eff)
  );

  evt_arb_flags #(.TRAP_W(TRAP_W), .BP_N(BP_N), .SSTEP_BIT(SSTEP_BIT)) u_flags (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sel(sel), .frozen(frozen),
    .bp_hit(bp_hit), .trap_eff(trap_eff), .bp_match(bp_match),
    .tf_flag(tf_flag), .if_flag(if_flag), .intr_req(intr_req),
    .hold_req(hold_req), .bp_enable(bp_enable), .smi_evt(smi_evt),
    .nmi_evt(nmi_evt), .nmi_unmask(nmi_unmask), .halt_evt(halt_evt),
    .rf_evt(rf_evt), .trap_evt(trap_evt), .inhibit_evt(inhibit_evt),
    .smi_q(smi_pending), .nmi_q(nmi_pending), .dis_q(nmi_disable),
    .halted_q(halted), .rf_q(resume), .evp_q(event_pending),
    .trap_q(trap_pending), .stat_q(dbg_status), .inh_q(inhibit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= '0;
      vec_q  <= '0;
      ext_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept && (sel != SEL_NONE)) begin
          kind_q <= '0;
          vec_q  <= '0;
          ext_q  <= 1'b0;
          st_q   <= ST_CMD;
          unique case (sel)
            SEL_TSW, SEL_DBG, SEL_BP: begin
              kind_q[K_DBG] <= 1'b1;
              vec_q         <= DBG_V;
            end
            SEL_SMI:  kind_q[K_SMI] <= 1'b1;
            SEL_NMI: begin
              kind_q[K_NMI] <= 1'b1;
              vec_q         <= NMI_V;
              ext_q         <= 1'b1;
            end
            SEL_INTR: st_q <= ST_ACK;
            SEL_HOLD: kind_q[K_HOLD] <= 1'b1;
            default:  st_q <= ST_IDLE;
          endcase
        end
        ST_ACK: if (iack_valid) begin
          kind_q        <= '0;
          kind_q[K_INT] <= 1'b1;
          vec_q         <= iack_vector;
          ext_q         <= 1'b1;
          st_q          <= ST_CMD;
        end
        ST_CMD: if (cmd_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign iack_req     = (st_q == ST_ACK);
  assign cmd_valid    = (st_q == ST_CMD);
  assign cmd_kind     = kind_q;
  assign cmd_vector   = vec_q;
  assign cmd_external = ext_q;
endmodule

// File: rtl/evt_arb_chk.sv
module evt_arb_chk
  import evt_arb_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned NMI_VEC = 2,
  parameter int unsigned DBG_VEC = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bnd_valid,
  input logic             bnd_ready,
  input logic             halted,
  input logic [1:0]       inhibit_evt,
  input logic [1:0]       inhibit,
  input logic             iack_req,
  input logic             iack_valid,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [4:0]       cmd_kind,
  input logic [VEC_W-1:0] cmd_vector,
  input logic             cmd_external,
  input logic             nmi_disable
);
  AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_kind) == 1); // R1
  AST_CMD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_vector)); // R1
  AST_BUSY_NO_BND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || iack_req) |-> !bnd_ready); // R1
  AST_DBG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind[K_DBG] |-> cmd_vector == VEC_W'(DBG_VEC) && !cmd_external); // R2
  AST_SMI_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_kind[K_SMI] |-> nmi_disable); // R3
  AST_NMI_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind[K_NMI] |-> cmd_vector == VEC_W'(NMI_VEC) && cmd_external); // R6
  AST_NMI_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_kind[K_NMI] |-> nmi_disable); // R6
  AST_INTR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_kind[K_INT] |-> $past(iack_req) && $past(iack_valid) && cmd_external); // R7
  AST_INHIB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid && bnd_ready && !halted && inhibit_evt == 2'b00 |=> inhibit == 2'b00); // R12
endmodule

bind evt_arb evt_arb_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .DBG_VEC(DBG_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
  .halted(halted), .inhibit_evt(inhibit_evt), .inhibit(inhibit),
  .iack_req(iack_req), .iack_valid(iack_valid), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_vector(cmd_vector),
  .cmd_external(cmd_external), .nmi_disable(nmi_disable)
);

// File: tb/evt_arb_tb.sv
module evt_arb_tb;
  localparam int TW = 16;
  localparam int VW = 8;
  localparam int BN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic bnd_valid = 0, bnd_ready;
  logic if_flag = 0, tf_flag = 0, in_smm = 0, mwait_ovr = 0, intr_req = 0, hold_req = 0;
  logic bp_enable = 0;
  logic [BN-1:0] bp_match = '0;
  logic smi_evt = 0, nmi_evt = 0, nmi_unmask = 0, halt_evt = 0, rf_evt = 0;
  logic [TW-1:0] trap_evt = '0;
  logic [1:0] inhibit_evt = '0;
  logic iack_req, iack_valid = 0;
  logic [VW-1:0] iack_vector = '0;
  logic cmd_valid, cmd_ready = 0, cmd_external;
  logic [4:0] cmd_kind;
  logic [VW-1:0] cmd_vector;
  logic [TW-1:0] dbg_status, trap_pending;
  logic [1:0] inhibit;
  logic resume, smi_pending, nmi_pending, nmi_disable, halted, event_pending;

  evt_arb u_dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic m_smi = 0, m_nmi = 0, m_dis = 0, m_halt = 0, m_rf = 0, m_evp = 0;
  logic [TW-1:0] m_trap = '0, m_stat = '0;
  logic [1:0] m_inh = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic s, input logic n, input logic un, input logic h,
                       input logic r, input logic [TW-1:0] t, input logic [1:0] ih);
    @(negedge clk);
    smi_evt = s; nmi_evt = n; nmi_unmask = un; halt_evt = h; rf_evt = r;
    trap_evt = t; inhibit_evt = ih;
    @(negedge clk);
    smi_evt = 0; nmi_evt = 0; nmi_unmask = 0; halt_evt = 0; rf_evt = 0;
    trap_evt = '0; inhibit_evt = '0;
    if (un) m_dis = 0;
    m_smi |= s; m_nmi |= n; m_trap |= t; m_inh |= ih;
    if (r) m_rf = 1;
    if (h) m_halt = 1;
    if (s || n || (t != 0)) m_evp = 1;
  endtask

  // outcome codes: 0 none, 1 task-switch, 2 smi, 3 debug, 4 nmi, 5 intr, 6 hold, 7 breakpoint
  task automatic boundary(input logic ifl, input logic tf, input logic smm, input logic mw,
                          input logic ir, input logic hr, input logic bpe,
                          input logic [BN-1:0] bpm, input logic [VW-1:0] vec);
    int oc;
    logic wake, sleepy, bph, ext_ok;
    logic [4:0] ekind;
    logic [VW-1:0] evec;
    string tag;
    // model
    wake = (ir && (ifl || mw)) || m_nmi || m_smi;
    sleepy = m_halt && !wake;
    oc = 0;
    if (!sleepy) begin
      if (m_halt) begin m_halt = 0; m_trap = '0; m_inh = '0; end
      bph = !m_rf && bpe && (bpm != 0);
      ext_ok = !m_inh[1];
      if (m_trap[15]) oc = 1;
      else if (m_smi && !smm) oc = 2;
      else if (m_trap != 0 && !m_inh[0]) oc = 3;
      else if (ext_ok && m_nmi && !m_dis) oc = 4;
      else if (ext_ok && ir && ifl) oc = 5;
      else if (ext_ok && hr) oc = 6;
      else if (bph && !m_inh[0]) oc = 7;
      if (oc == 2) begin m_smi = 0; m_dis = 1; end
      if (oc == 4) begin m_nmi = 0; m_dis = 1; end
      if (oc == 1 || oc == 3) m_stat |= m_trap;
      if (oc == 7) m_stat |= TW'(bpm);
      if (oc == 1 || oc == 3 || oc == 7) m_trap = '0;
      else begin
        if (bph) m_trap |= TW'(bpm);
        if (tf && (oc == 0 || oc == 6)) m_trap[14] = 1'b1;
      end
      m_inh = '0; m_rf = 0;
      m_evp = m_smi || m_nmi || (ir && ifl) || (m_trap != 0) || hr || tf || bpe;
    end
    case (oc)
      1: begin ekind = 5'b00001; evec = 1; tag = "R2"; end
      2: begin ekind = 5'b00010; evec = 0; tag = "R3"; end
      3: begin ekind = 5'b00001; evec = 1; tag = "R4"; end
      4: begin ekind = 5'b00100; evec = 2; tag = "R6"; end
      5: begin ekind = 5'b01000; evec = vec; tag = "R7"; end
      6: begin ekind = 5'b10000; evec = 0; tag = "R8"; end
      7: begin ekind = 5'b00001; evec = 1; tag = "R10"; end
      default: begin ekind = 0; evec = 0; tag = sleepy ? "R11" : "R5"; end
    endcase
    // drive
    @(negedge clk);
    chk("R1 ready before offer", bnd_ready, 1);
    if_flag = ifl; tf_flag = tf; in_smm = smm; mwait_ovr = mw; intr_req = ir;
    hold_req = hr; bp_enable = bpe; bp_match = bpm; bnd_valid = 1;
    @(negedge clk);
    bnd_valid = 0;
    if (oc == 5) begin
      chk("R7 iack_req", iack_req, 1);
      iack_valid = 1; iack_vector = vec;
      @(negedge clk);
      iack_valid = 0;
    end
    if (oc != 0) begin
      chk({tag, " cmd_valid"}, cmd_valid, 1);
      chk({tag, " kind"}, cmd_kind, ekind);
      chk({tag, " vector"}, cmd_vector, evec);
      chk({tag, " external"}, cmd_external, (oc == 4 || oc == 5));
      for (int k = 0; k < int'($urandom % 3); k++) begin
        @(negedge clk);
        chk("R1 command held", {cmd_valid, cmd_kind}, {1'b1, ekind});
        chk("R1 no new boundary", bnd_ready, 0);
      end
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
    end else begin
      chk({tag, " no command"}, {cmd_valid, iack_req}, 0);
    end
    chk("R2 dbg_status", dbg_status, m_stat);
    chk("R9 trap_pending", trap_pending, m_trap);
    chk("R6 nmi_disable", nmi_disable, m_dis);
    chk("R6 nmi_pending", nmi_pending, m_nmi);
    chk("R3 smi_pending", smi_pending, m_smi);
    chk("R11 halted", halted, m_halt);
    chk("R12 inhibit", inhibit, m_inh);
    chk("R10 resume", resume, m_rf);
    chk("R12 event_pending", event_pending, m_evp);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd5501);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", bnd_ready, 1);
    chk("R1 reset cmd", {cmd_valid, iack_req}, 0);
    chk("R12 reset state", {dbg_status, trap_pending, inhibit, resume, smi_pending,
        nmi_pending, nmi_disable, halted, event_pending}, 0);

    // R2: task switch beats SMI
    pulse(1, 0, 0, 0, 0, 16'h8001, 2'b00);
    boundary(0, 0, 0, 0, 0, 0, 0, 0, 0);
    boundary(0, 0, 0, 0, 0, 0, 0, 0, 0);           // SMI now (R3)
    // R3: SMI blocked in SMM, NMI blocked by lockout, interrupt goes (R7)
    pulse(1, 1, 0, 0, 0, 0, 2'b00);
    boundary(1, 0, 1, 0, 1, 0, 0, 0, 8'h41);
    pulse(0, 0, 1, 0, 0, 0, 2'b00);                // unmask
    boundary(0, 0, 1, 0, 0, 0, 0, 0, 0);           // NMI (R6)
    boundary(0, 0, 0, 0, 0, 0, 0, 0, 0);           // SMI
    // R4: debug inhibit keeps traps; R5: interrupt inhibit blocks hold
    pulse(0, 0, 0, 0, 0, 16'h0004, 2'b11);
    boundary(1, 0, 0, 0, 1, 1, 0, 0, 8'h22);
    boundary(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: single-step pending after hold grant (R8)
    boundary(0, 1, 0, 0, 0, 1, 0, 0, 0);
    boundary(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: resume suppresses breakpoint, then breakpoint fault
    pulse(0, 0, 0, 0, 1, 0, 2'b00);
    boundary(0, 0, 0, 0, 0, 0, 1, 4'b0101, 0);
    boundary(0, 0, 0, 0, 0, 0, 1, 4'b0010, 0);
    // R11: halt holds until wake
    pulse(0, 0, 0, 1, 0, 16'h0002, 2'b01);
    boundary(0, 0, 0, 0, 1, 1, 0, 0, 0);
    boundary(0, 0, 0, 1, 1, 0, 0, 0, 8'h77);

    for (int i = 0; i < 600; i++) begin
      logic [TW-1:0] tv;
      tv = '0;
      if ($urandom % 4 == 0) tv = TW'($urandom % 16);
      if ($urandom % 12 == 0) tv[15] = 1'b1;
      if ($urandom % 2 == 0)
        pulse(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
              ($urandom % 12) == 0, ($urandom % 6) == 0, tv, 2'($urandom % 4));
      boundary(($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
               ($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
               ($urandom % 4) == 0, BN'($urandom), VW'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule